// File: doc/BRIEF.md
# Multiprocessor-mode UART receiver

This block is an asynchronous serial receiver for a shared line on which one host talks to many stations. Every frame has a start bit, eight data bits sent least significant bit first, one multiprocessor bit and one stop bit. A multiprocessor bit of 1 marks an address (station ID) frame. A multiprocessor bit of 0 marks a data frame.

When software sets the wake-up filter, the receiver drops data frames without any trace. The next address frame is stored, sets the ready flag, raises the interrupt and disarms the filter in hardware, so the data frames after it arrive normally. Software compares the received ID with its own. If the ID does not match, software sets the filter again and the station goes back to waiting. The line is oversampled at 16 ticks per bit. A programmable divider makes those ticks from the core clock.

Top module: `mp_uart_rx`

## Requirements
- R1: With a tick every `div_i`+1 clocks and a bit period of 16 ticks, a frame is received with data least significant bit first. The data appears on `rx_data_o` and the multiprocessor bit on `mp_bit_o`.
- R2: While `arm_o` is 1, a frame whose multiprocessor bit is 0 is dropped. `rx_data_o`, `mp_bit_o`, `ready_o` and `irq_o` do not change.
- R3: A frame whose multiprocessor bit is 1 and that finds `ready_o` low is always stored. It sets `ready_o` and gives a one-cycle `irq_o` pulse. A stored frame never gives more than one pulse.
- R4: An accepted frame whose multiprocessor bit is 1 clears `arm_o` in hardware. After that, frames with the multiprocessor bit at 0 are received normally.
- R5: A one-cycle pulse on `rd_i` clears `ready_o`, `frame_err_o` and `overrun_o`.
- R6: A pulse on `arm_set_i` sets `arm_o` to 1 at any time. If it falls in the same cycle as a hardware clear, `arm_o` is still set.
- R7: While `rx_en_i` is 0, the line is ignored. A frame sent during that time changes no output.
- R8: If an accepted frame completes while `ready_o` is 1, `overrun_o` is set. The buffer keeps its old contents and no interrupt is raised.
- R9: A stored frame whose stop bit is sampled low sets `frame_err_o`. Its data is still stored.
- R10: A low pulse shorter than half a bit period does not start a frame.
- R11: A frame dropped by the filter sets neither `frame_err_o` nor `overrun_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| div_i | input | DIV_W | Clocks per oversample tick, minus one |
| rx_en_i | input | 1 | Receive enable |
| arm_set_i | input | 1 | Host write pulse that sets the wake-up filter |
| rd_i | input | 1 | Host read pulse of the receive buffer |
| rx_data_o | output | DATA_W | Receive buffer |
| mp_bit_o | output | 1 | Multiprocessor bit of the buffered frame |
| ready_o | output | 1 | Buffer holds unread data |
| arm_o | output | 1 | Wake-up filter armed |
| frame_err_o | output | 1 | Stop bit was low on a stored frame |
| overrun_o | output | 1 | Accepted frame lost because the buffer was full |
| irq_o | output | 1 | Reception-complete pulse |

## Verification
The bench builds the block with DIV_W of 4, keeps DATA_W at 8 and OVS at 16, and drives `div_i` at 2. This gives a 48-clock bit, so several dozen frames fit in a short run. Random frames mix the filter state, the multiprocessor bit, bad stop bits and host reads. This reaches drop, wake-up, overrun and framing-error sequences back to back. Directed cases cover a start glitch, a disabled receiver and an arm write that meets an address frame.

// File: rtl/mpu_rx_pkg.sv
package mpu_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/mpu_rx_tick_gen.sv
module mpu_rx_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == div_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mpu_rx_sync.sv
module mpu_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/mpu_rx_frame.sv
module mpu_rx_frame
  import mpu_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rx_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              mp_o,
  output logic              stop_ok_o
);
  localparam int CNT_W  = $clog2(OVS);
  localparam int BIDX_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0]  HALF_M1 = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0]  FULL_M1 = CNT_W'(OVS - 1);
  localparam logic [BIDX_W-1:0] LAST_B  = BIDX_W'(DATA_W);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIDX_W-1:0] bidx_q;
  logic [DATA_W:0]   sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      bidx_q    <= '0;
      sh_q      <= '0;
      done_o    <= 1'b0;
      stop_ok_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (tick_i) begin
        unique case (state_q)
          ST_IDLE: if (!rx_i) begin
            state_q <= ST_START;
            cnt_q   <= '0;
          end
          ST_START: begin
            if (cnt_q == HALF_M1) begin
              // confirm start at mid-bit, else treat as glitch
              state_q <= rx_i ? ST_IDLE : ST_BITS;
              cnt_q   <= '0;
              bidx_q  <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_BITS: begin
            if (cnt_q == FULL_M1) begin
              cnt_q <= '0;
              sh_q  <= {rx_i, sh_q[DATA_W:1]};
              if (bidx_q == LAST_B) state_q <= ST_STOP;
              else bidx_q <= bidx_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP: begin
            if (cnt_q == FULL_M1) begin
              cnt_q     <= '0;
              state_q   <= ST_IDLE;
              done_o    <= 1'b1;
              stop_ok_o <= rx_i;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign data_o = sh_q[DATA_W-1:0];
  assign mp_o   = sh_q[DATA_W];

  p_idle_when_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == ST_IDLE && !done_o));

  p_done_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              rx_en_i,
  input  logic              arm_set_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              mp_bit_o,
  output logic              ready_o,
  output logic              arm_o,
  output logic              frame_err_o,
  output logic              overrun_o,
  output logic              irq_o
);
  logic              tick, rx_s;
  logic              f_done, f_mp, f_stop_ok;
  logic [DATA_W-1:0] f_data;
  logic              accept, store;

  mpu_rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i), .div_i(div_i), .tick_o(tick)
  );

  mpu_rx_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s)
  );

  mpu_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i), .tick_i(tick), .rx_i(rx_s),
    .done_o(f_done), .data_o(f_data), .mp_o(f_mp), .stop_ok_o(f_stop_ok)
  );

  // filter: address frames always pass, data frames only when disarmed
  assign accept = f_done && (!arm_o || f_mp);
  assign store  = accept && !ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o   <= '0;
      mp_bit_o    <= 1'b0;
      ready_o     <= 1'b0;
      arm_o       <= 1'b0;
      frame_err_o <= 1'b0;
      overrun_o   <= 1'b0;
      irq_o       <= 1'b0;
    end else begin
      irq_o <= store;
      if (rd_i) begin
        ready_o     <= 1'b0;
        frame_err_o <= 1'b0;
        overrun_o   <= 1'b0;
      end
      if (store) begin
        rx_data_o <= f_data;
        mp_bit_o  <= f_mp;
        ready_o   <= 1'b1;
        if (!f_stop_ok) frame_err_o <= 1'b1;
      end else if (accept) begin
        overrun_o <= 1'b1;
      end
      if (arm_set_i)          arm_o <= 1'b1;
      else if (accept && f_mp) arm_o <= 1'b0;
    end
  end

  p_drop_keeps_buf_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_done && arm_o && !f_mp && !rd_i) |=>
      ($stable(rx_data_o) && $stable(ready_o) && !irq_o));

  p_drop_no_err_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_done && arm_o && !f_mp && !rd_i) |=>
      ($stable(frame_err_o) && $stable(overrun_o)));

  p_irq_with_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ready_o);

  p_arm_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_done && f_mp && !arm_set_i) |=> !arm_o);

  p_arm_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_set_i |=> arm_o);

  p_rd_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !f_done) |=> (!ready_o && !overrun_o && !frame_err_o));

  p_no_overwrite_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !rd_i) |=> ($stable(rx_data_o) && $stable(mp_bit_o)));
endmodule

// File: tb/mp_uart_rx_tb_top.sv
module mp_uart_rx_tb_top;
  localparam int DATA_W = 8;
  localparam int OVS    = 16;
  localparam int DIV_W  = 4;
  localparam int DIV    = 2;
  localparam int BIT    = OVS * (DIV + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic [DIV_W-1:0] div = DIV_W'(DIV);
  logic en = 1'b0, arm_set = 1'b0, rd = 1'b0;
  logic [DATA_W-1:0] rx_data;
  logic mp_bit, ready, arm, ferr, ovr, irq;

  int checks = 0, errors = 0, irq_cnt = 0;
  logic [DATA_W-1:0] m_data = '0;
  logic m_mp = 0, m_ready = 0, m_arm = 0, m_ferr = 0, m_ovr = 0;
  int m_irq = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mp_uart_rx #(.DATA_W(DATA_W), .OVS(OVS), .DIV_W(DIV_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .div_i(div), .rx_en_i(en),
    .arm_set_i(arm_set), .rd_i(rd), .rx_data_o(rx_data), .mp_bit_o(mp_bit),
    .ready_o(ready), .arm_o(arm), .frame_err_o(ferr), .overrun_o(ovr), .irq_o(irq)
  );

  always @(posedge clk) if (irq) irq_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " data"},  rx_data, m_data);
    chk({req, " mp"},    mp_bit,  m_mp);
    chk({req, " ready"}, ready,   m_ready);
    chk({req, " arm"},   arm,     m_arm);
    chk({req, " ferr"},  ferr,    m_ferr);
    chk({req, " ovr"},   ovr,     m_ovr);
    chk({req, " irq"},   irq_cnt, m_irq);
  endtask

  task automatic send_frame(input logic [DATA_W-1:0] d, input logic mp, input logic stop);
    logic [DATA_W+2:0] bits = {stop, mp, d, 1'b0};
    for (int i = 0; i < DATA_W + 3; i++) begin
      rx = bits[i];
      repeat (BIT) @(negedge clk);
    end
    rx = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    // model
    if (en && (!m_arm || mp)) begin
      if (mp) m_arm = 1'b0;
      if (m_ready) m_ovr = 1'b1;
      else begin
        m_data = d; m_mp = mp; m_ready = 1'b1; m_irq++;
        if (!stop) m_ferr = 1'b1;
      end
    end
  endtask

  task automatic host_read();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
    m_ready = 0; m_ferr = 0; m_ovr = 0;
    @(negedge clk);
  endtask

  task automatic host_arm();
    @(negedge clk) arm_set = 1'b1;
    @(negedge clk) arm_set = 1'b0;
    m_arm = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    check_all("reset");
    rst_n = 1'b1;
    en = 1'b1;
    repeat (10) @(negedge clk);

    // R1 basic reception, LSB first
    send_frame(8'hA5, 1'b0, 1'b1);
    check_all("R1 basic");
    host_read();
    check_all("R5 read clears");

    // R2/R11 armed drop of data frame with bad stop
    host_arm();
    send_frame(8'h3C, 1'b0, 1'b0);
    check_all("R2 R11 dropped");

    // R3/R4 address frame accepted, filter disarms
    send_frame(8'h81, 1'b1, 1'b1);
    check_all("R3 R4 address");
    host_read();
    send_frame(8'h42, 1'b0, 1'b1);
    check_all("R4 data after wake");

    // R8 overrun keeps buffer
    send_frame(8'h99, 1'b0, 1'b1);
    check_all("R8 overrun");
    host_read();

    // R9 framing error
    send_frame(8'h0F, 1'b0, 1'b0);
    check_all("R9 framing");
    host_read();

    // R10 start glitch
    rx = 1'b0;
    repeat (BIT / 4) @(negedge clk);
    rx = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    check_all("R10 glitch");

    // R7 disabled receiver
    en = 1'b0;
    send_frame(8'h77, 1'b1, 1'b1);
    check_all("R7 disabled");
    en = 1'b1;
    repeat (4) @(negedge clk);

    // R6 arm write while an address frame completes: arm must stay set
    fork
      send_frame(8'hC3, 1'b1, 1'b1);
      begin
        for (int k = 0; k < (DATA_W + 2) * BIT + BIT / 2 + 8; k++) begin
          @(negedge clk);
          arm_set = 1'b1;
        end
        repeat (BIT) @(negedge clk);
        arm_set = 1'b0;
      end
    join
    m_arm = 1'b1;
    check_all("R6 arm priority");
    host_read();

    // random mix
    for (int n = 0; n < 30; n++) begin
      logic [DATA_W-1:0] d = DATA_W'($urandom);
      logic mp = 1'($urandom % 2);
      logic st = ($urandom % 8) != 0;
      if ($urandom % 3 == 0) host_arm();
      if ($urandom % 2 == 0) host_read();
      send_frame(d, mp, st);
      check_all("R1 R2 R3 R4 R8 R9 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule